// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Word Codec

This block guards an 8-bit data word with a 13-bit extended Hamming codeword. The encode path takes a data byte and produces a codeword. In that codeword, four check bits sit at the power-of-two positions and one overall parity bit sits at position 0. Each check bit sits at a position of the form 2^k. It is chosen so that every position whose binary index has bit k set XORs to zero.

The decode path takes a codeword that may have been corrupted. It recomputes the four checks into a syndrome and also recomputes the overall parity. The syndrome is the 1-based position of a single flipped bit. The parity bit tells a single error, which can be repaired, apart from a double error, which can only be reported.

Both paths are independent and are registered once. A result appears on the outputs one clock after its input is sampled.

Top module: `secded_codec`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output is zero.
- R2: Codeword bit p holds position p. Check bits occupy positions 1, 2, 4 and 8. Data bits 0 to 7 occupy positions 3, 5, 6, 7, 9, 10, 11 and 12, in that order.
- R3: For each k from 0 to 3, the XOR of all codeword positions 1 to 12 whose index has bit k set is zero in every encoded word.
- R4: Codeword bit 0 makes the count of ones across all 13 bits even.
- R5: Each path has a latency of one clock. The encoded word and the decoded result reflect the inputs sampled at the previous rising edge and stay unchanged between edges.
- R6: A codeword with zero syndrome and even overall parity returns its data bits with both error flags low.
- R7: A codeword with exactly one flipped bit in positions 1 to 12 returns the original data with the single flag high and the double flag low.
- R8: A codeword whose only flipped bit is bit 0 returns the original data with the single flag high and the double flag low.
- R9: A codeword with two flipped bits raises the double flag, leaves the single flag low, and returns the data positions of the received word unmodified.
- R10: A nonzero syndrome above 12 with odd overall parity raises the double flag, leaves the single flag low, and returns the received data positions unmodified.
- R11: The single and double flags are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_data_i | input | 8 | Data byte to encode |
| enc_code_o | output | 13 | Registered codeword for enc_data_i |
| dec_code_i | input | 13 | Received codeword to check |
| dec_data_o | output | 8 | Registered data after correction |
| dec_single_o | output | 1 | A single error was found and repaired |
| dec_double_o | output | 1 | An uncorrectable error was found |

## Verification
Four properties hold on every cycle:
- the encoded word always has even weight;
- its data positions always carry the byte sampled one edge earlier;
- the two flags are never high together;
- an input of even weight never produces a single-error report.

The cycle-level properties cannot tell whether the right bit was repaired, whether the check bits satisfy their coverage sets, or what an out-of-range syndrome does. The directed scenarios establish those: they flip every bit position, many bit pairs, and chosen triples, then compare the data and flags against an independent model.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int DATA_W = 8;

    function automatic int calc_chk_w(input int dw);
        int r;
        r = 0;
        while ((1 << r) < dw + r + 1) r++;
        return r;
    endfunction

    localparam int CHK_W  = calc_chk_w(DATA_W);
    localparam int CODE_W = DATA_W + CHK_W + 1;
    localparam int TOP_POS = CODE_W - 1;

    function automatic bit is_pow2(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // position of data bit idx inside the codeword
    function automatic int data_pos(input int idx);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 1; p < CODE_W; p++) begin
            if (!is_pow2(p)) begin
                if (cnt == idx) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

    function automatic logic [DATA_W-1:0] pull_data(input logic [CODE_W-1:0] cw);
        logic [DATA_W-1:0] d;
        for (int i = 0; i < DATA_W; i++) d[i] = cw[data_pos(i)];
        return d;
    endfunction

    typedef struct packed {
        logic [CODE_W-1:0] enc_code;
        logic [DATA_W-1:0] dec_data;
        logic              dec_single;
        logic              dec_double;
    } codec_regs_t;

endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);
    logic [CODE_W-1:0] work;
    logic              chk;

    always_comb begin
        work = '0;
        for (int i = 0; i < DATA_W; i++) begin
            work[data_pos(i)] = data_i[i];
        end
        for (int k = 0; k < CHK_W; k++) begin
            chk = 1'b0;
            for (int p = 1; p < CODE_W; p++) begin
                if (((p >> k) & 1) == 1) chk = chk ^ work[p];
            end
            work[1 << k] = chk;
        end
        work[0] = ^work[CODE_W-1:1];
        code_o  = work;
    end
endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome
    import secded_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [CHK_W-1:0]  syn_o,
    output logic              par_odd_o
);
    always_comb begin
        syn_o = '0;
        for (int k = 0; k < CHK_W; k++) begin
            for (int p = 1; p < CODE_W; p++) begin
                if (((p >> k) & 1) == 1) syn_o[k] = syn_o[k] ^ code_i[p];
            end
        end
        par_odd_o = ^code_i;
    end
endmodule

// File: rtl/secded_corrector.sv
module secded_corrector
    import secded_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic [CHK_W-1:0]  syn_i,
    input  logic              par_odd_i,
    output logic [DATA_W-1:0] data_o,
    output logic              single_o,
    output logic              double_o
);
    logic [CODE_W-1:0] fixed;
    logic              in_range;

    assign in_range = (int'(syn_i) <= TOP_POS);

    always_comb begin
        fixed    = code_i;
        single_o = 1'b0;
        double_o = 1'b0;
        if (syn_i == '0) begin
            // only the overall parity bit can be wrong here
            single_o = par_odd_i;
        end else if (par_odd_i && in_range) begin
            fixed[int'(syn_i)] = ~code_i[int'(syn_i)];
            single_o = 1'b1;
        end else begin
            double_o = 1'b1;
        end
        data_o = pull_data(fixed);
    end
endmodule

// File: rtl/secded_codec.sv
module secded_codec
    import secded_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CODE_W-1:0] enc_code_o,
    input  logic [CODE_W-1:0] dec_code_i,
    output logic [DATA_W-1:0] dec_data_o,
    output logic              dec_single_o,
    output logic              dec_double_o
);
    logic [CODE_W-1:0] enc_code;
    logic [CHK_W-1:0]  syn;
    logic              par_odd;
    logic [DATA_W-1:0] fix_data;
    logic              fix_single;
    logic              fix_double;

    codec_regs_t regs_d, regs_q;

    secded_encoder u_enc (
        .data_i (enc_data_i),
        .code_o (enc_code)
    );

    secded_syndrome u_syn (
        .code_i    (dec_code_i),
        .syn_o     (syn),
        .par_odd_o (par_odd)
    );

    secded_corrector u_fix (
        .code_i    (dec_code_i),
        .syn_i     (syn),
        .par_odd_i (par_odd),
        .data_o    (fix_data),
        .single_o  (fix_single),
        .double_o  (fix_double)
    );

    always_comb begin
        regs_d            = regs_q;
        regs_d.enc_code   = enc_code;
        regs_d.dec_data   = fix_data;
        regs_d.dec_single = fix_single;
        regs_d.dec_double = fix_double;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign enc_code_o   = regs_q.enc_code;
    assign dec_data_o   = regs_q.dec_data;
    assign dec_single_o = regs_q.dec_single;
    assign dec_double_o = regs_q.dec_double;
endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk
    import secded_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] enc_data_i,
    input logic [CODE_W-1:0] enc_code_o,
    input logic [CODE_W-1:0] dec_code_i,
    input logic              dec_single_o,
    input logic              dec_double_o
);
    a_r4_even_weight: assert property (@(posedge clk) disable iff (!rst_n)
        (^enc_code_o) == 1'b0);

    a_r2_data_placed: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pull_data(enc_code_o) == $past(enc_data_i));

    a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_single_o && dec_double_o));

    a_r9_even_no_single: assert property (@(posedge clk) disable iff (!rst_n)
        ((^dec_code_i) == 1'b0) |=> !dec_single_o);
endmodule

bind secded_codec secded_codec_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enc_data_i   (enc_data_i),
    .enc_code_o   (enc_code_o),
    .dec_code_i   (dec_code_i),
    .dec_single_o (dec_single_o),
    .dec_double_o (dec_double_o)
);

// File: tb/secded_codec_bench.sv
module secded_codec_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int CW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] enc_data_i = '0;
    logic [CW-1:0] enc_code_o;
    logic [CW-1:0] dec_code_i = '0;
    logic [DW-1:0] dec_data_o;
    logic          dec_single_o;
    logic          dec_double_o;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    secded_codec u_secded_codec (
        .clk(clk), .rst_n(rst_n),
        .enc_data_i(enc_data_i), .enc_code_o(enc_code_o),
        .dec_code_i(dec_code_i), .dec_data_o(dec_data_o),
        .dec_single_o(dec_single_o), .dec_double_o(dec_double_o)
    );

    // data bit positions from R2
    function automatic int m_pos(input int i);
        int tbl [8] = '{3, 5, 6, 7, 9, 10, 11, 12};
        return tbl[i];
    endfunction

    function automatic logic [CW-1:0] m_encode(input logic [DW-1:0] d);
        logic [CW-1:0] c;
        logic x;
        c = '0;
        for (int i = 0; i < DW; i++) c[m_pos(i)] = d[i];
        for (int k = 0; k < 4; k++) begin
            x = 1'b0;
            for (int p = 1; p < CW; p++)
                if (p != (1 << k) && ((p >> k) & 1) == 1) x ^= c[p];
            c[1 << k] = x;
        end
        c[0] = ^c[CW-1:1];
        return c;
    endfunction

    function automatic logic [DW-1:0] m_extract(input logic [CW-1:0] c);
        logic [DW-1:0] d;
        for (int i = 0; i < DW; i++) d[i] = c[m_pos(i)];
        return d;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [DW-1:0] d, input logic [CW-1:0] c);
        @(negedge clk);
        enc_data_i = d;
        dec_code_i = c;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_dec(input string req, input logic [DW-1:0] d,
                              input logic s, input logic dd);
        check(req, "data", 32'(dec_data_o), 32'(d));
        check(req, "single", 32'(dec_single_o), 32'(s));
        check(req, "double", 32'(dec_double_o), 32'(dd));
    endtask

    task automatic t_reset;
        check("R1", "enc_code", 32'(enc_code_o), 32'h0);
        expect_dec("R1", '0, 1'b0, 1'b0);
    endtask

    task automatic t_encode_all;
        logic [CW-1:0] c;
        for (int v = 0; v < 256; v++) begin
            drive(DW'(v), m_encode(DW'(v)));
            c = enc_code_o;
            check("R2", "codeword", 32'(c), 32'(m_encode(DW'(v))));
            check("R4", "weight even", 32'(^c), 32'h0);
            for (int k = 0; k < 4; k++) begin
                logic x;
                x = 1'b0;
                for (int p = 1; p < CW; p++) if (((p >> k) & 1) == 1) x ^= c[p];
                check("R3", "coverage xor", 32'(x), 32'h0);
            end
            expect_dec("R6", DW'(v), 1'b0, 1'b0);
        end
    endtask

    task automatic t_latency;
        drive(8'h11, m_encode(8'h11));
        @(negedge clk);
        enc_data_i = 8'hEE;
        dec_code_i = m_encode(8'hEE);
        #1;
        check("R5", "enc held", 32'(enc_code_o), 32'(m_encode(8'h11)));
        check("R5", "dec held", 32'(dec_data_o), 32'h11);
        @(posedge clk);
        #1;
        check("R5", "enc next", 32'(enc_code_o), 32'(m_encode(8'hEE)));
        check("R5", "dec next", 32'(dec_data_o), 32'hEE);
    endtask

    task automatic t_single;
        logic [DW-1:0] pats [5] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81};
        for (int j = 0; j < 5; j++) begin
            for (int b = 0; b < CW; b++) begin
                drive(pats[j], m_encode(pats[j]) ^ (CW'(1) << b));
                if (b == 0) expect_dec("R8", pats[j], 1'b1, 1'b0);
                else        expect_dec("R7", pats[j], 1'b1, 1'b0);
                check("R11", "flags", 32'(dec_single_o & dec_double_o), 32'h0);
            end
        end
    endtask

    task automatic t_double;
        logic [CW-1:0] bad;
        for (int a = 0; a < CW; a++) begin
            for (int b = a + 1; b < CW; b++) begin
                bad = m_encode(8'hA5) ^ (CW'(1) << a) ^ (CW'(1) << b);
                drive(8'hA5, bad);
                expect_dec("R9", m_extract(bad), 1'b0, 1'b1);
            end
        end
    endtask

    task automatic t_out_of_range;
        logic [CW-1:0] bad;
        // positions 1,4,8 -> syndrome 13, odd weight
        bad = m_encode(8'h5A) ^ 13'h0112;
        drive(8'h5A, bad);
        expect_dec("R10", m_extract(bad), 1'b0, 1'b1);
        // positions 3,4,8 -> syndrome 15, odd weight
        bad = m_encode(8'hC3) ^ 13'h0118;
        drive(8'hC3, bad);
        expect_dec("R10", m_extract(bad), 1'b0, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_encode_all();
        t_latency();
        t_single();
        t_double();
        t_out_of_range();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule